// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block keeps one cache coherent with its peers on a shared bus. It uses a write-broadcast scheme: a local write to a line that other caches also hold goes out on the bus as an update word, and the peers overwrite their copies instead of dropping them. A write to a line nobody else holds stays inside the cache. Whether a line is shared is not remembered from history. The block samples a wired-OR shared signal each time it owns the bus, and decides from that sample.

The store is direct-mapped, with one data word, one tag and a five-valued coherence state per line. The states are invalid, valid-exclusive (clean, sole copy), shared-clean, shared-dirty (this cache owns the dirty word) and exclusive-dirty. Dirty words pass from cache to cache without touching memory. Memory is brought up to date only when a dirty line, shared or not, is evicted.

The CPU side is a simple held request. The bus side is a request/grant master port plus a snoop input port. Bus arbitration and memory are outside the block.

Top module: `wu_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid: a snoop gets no shared or supply response, and any CPU access first issues a bus read.
- R2: A CPU miss on a clean or invalid line issues a bus read (bus_cmd_o = 1) at the CPU address, where the low IDX_W address bits select the line and the rest form the tag. On grant the line is filled from bus_rdata_i, as shared-clean if bus_shared_i is high and valid-exclusive if not. A read then completes with the filled word.
- R3: A CPU write that hits a valid-exclusive or exclusive-dirty line completes without any bus request. The line becomes exclusive-dirty and holds the new word.
- R4: A CPU write that hits a shared-clean or shared-dirty line issues an update (bus_cmd_o = 2) carrying the address and the new word, and completes in the grant cycle. The line becomes shared-dirty if bus_shared_i is high at grant, and exclusive-dirty otherwise.
- R5: A miss whose victim line is shared-dirty or exclusive-dirty first issues a writeback (bus_cmd_o = 3) with the victim's address and word, and then the read. A clean victim is dropped silently.
- R6: A snooped read (snp_cmd_i = 1) that hits a line asserts snp_shared_o. If the line is dirty, the block also asserts snp_supply_o with the word on snp_data_o and keeps the line as shared-dirty. A clean line becomes shared-clean, with no supply.
- R7: A snooped update (snp_cmd_i = 2) that hits a line asserts snp_shared_o, overwrites the word with snp_data_o's source snp_data_i, and leaves the line shared-clean.
- R8: A snoop that misses (invalid line or other tag), or any snooped writeback (snp_cmd_i = 3), draws no response and changes nothing.
- R9: Once raised, bus_req_o stays high with stable command and address until bus_gnt_i is seen.
- R10: A snoop that hits a line in the same cycle as a CPU hit is served first. The CPU access then stalls one cycle and proceeds on the line's new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | CPU access request, held until done |
| cpu_we_i | input | 1 | CPU access is a write |
| cpu_addr_i | input | IDX_W+TAG_W | CPU word address, index in low bits |
| cpu_wdata_i | input | DW | CPU write word |
| cpu_done_o | output | 1 | Access completes this cycle |
| cpu_rdata_o | output | DW | Read word, valid with done |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant; the transfer completes in this cycle. Snoops are ignored while it is high |
| bus_cmd_o | output | 2 | 1 read, 2 update, 3 writeback |
| bus_addr_o | output | IDX_W+TAG_W | Transfer address |
| bus_wdata_o | output | DW | Update or writeback word |
| bus_rdata_i | input | DW | Fill word from memory or the owning peer |
| bus_shared_i | input | 1 | Wired-OR shared signal from the peers, sampled at grant |
| snp_valid_i | input | 1 | A peer's transfer is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same coding as bus_cmd_o |
| snp_addr_i | input | IDX_W+TAG_W | Snooped address |
| snp_data_i | input | DW | Snooped update word |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_supply_o | output | 1 | This cache supplies the dirty word |
| snp_data_o | output | DW | Supplied word |

## Verification
The collision of interest is a snoop hit and a local CPU hit in the same cycle, since both want the single store write port. The bench provokes it directly. It presents a CPU write to a valid-exclusive line and, in the same cycle, a snooped read of that line. It does the same for an exclusive-dirty line. In the shared cycle it checks that the snoop is answered from the old state (supply and word for the dirty case) and that the CPU is not done. Afterwards it checks that the write turns into a bus update, because the line is now shared.

// File: rtl/wu_pkg.sv
package wu_pkg;
  typedef enum logic [2:0] {
    LN_I  = 3'd0,
    LN_VE = 3'd1,
    LN_SC = 3'd2,
    LN_SD = 3'd3,
    LN_ED = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_UPD  = 2'd2,
    BUS_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CTL_IDLE,
    CTL_UPD,
    CTL_WB,
    CTL_FILL
  } ctl_e;

  function automatic logic st_dirty(line_st_e s);
    return (s == LN_SD) || (s == LN_ED);
  endfunction
endpackage

// File: rtl/wu_line_store.sv
module wu_line_store
  import wu_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6,
  parameter int DW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  line_st_e         wst_i,
  input  logic [TAG_W-1:0] wtag_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] a_idx_i,
  output line_st_e         a_st_o,
  output logic [TAG_W-1:0] a_tag_o,
  output logic [DW-1:0]    a_data_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output line_st_e         b_st_o,
  output logic [TAG_W-1:0] b_tag_o,
  output logic [DW-1:0]    b_data_o
);
  localparam int DEPTH = 1 << IDX_W;

  line_st_e         st_q   [DEPTH];
  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]   <= LN_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (we_i) begin
      st_q[widx_i]   <= wst_i;
      tag_q[widx_i]  <= wtag_i;
      data_q[widx_i] <= wdata_i;
    end
  end

  assign a_st_o   = st_q[a_idx_i];
  assign a_tag_o  = tag_q[a_idx_i];
  assign a_data_o = data_q[a_idx_i];
  assign b_st_o   = st_q[b_idx_i];
  assign b_tag_o  = tag_q[b_idx_i];
  assign b_data_o = data_q[b_idx_i];
endmodule

// File: rtl/wu_snoop_resp.sv
module wu_snoop_resp
  import wu_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int DW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  bus_cmd_e         cmd_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [DW-1:0]    data_i,
  input  line_st_e         ln_st_i,
  input  logic [TAG_W-1:0] ln_tag_i,
  input  logic [DW-1:0]    ln_data_i,
  output logic             shared_o,
  output logic             supply_o,
  output logic [DW-1:0]    data_o,
  output logic             wr_o,
  output line_st_e         wst_o,
  output logic [DW-1:0]    wdata_o
);
  logic hit;
  assign hit = valid_i && (ln_st_i != LN_I) && (ln_tag_i == tag_i);

  always_comb begin
    shared_o = 1'b0;
    supply_o = 1'b0;
    wr_o     = 1'b0;
    wst_o    = ln_st_i;
    wdata_o  = ln_data_i;
    if (hit) begin
      unique case (cmd_i)
        BUS_RD: begin
          shared_o = 1'b1;
          supply_o = st_dirty(ln_st_i);
          wr_o     = 1'b1;
          wst_o    = st_dirty(ln_st_i) ? LN_SD : LN_SC;
        end
        BUS_UPD: begin
          shared_o = 1'b1;
          wr_o     = 1'b1;
          wst_o    = LN_SC;
          wdata_o  = data_i;
        end
        default: ;
      endcase
    end
  end

  assign data_o = ln_data_i;

  // R6
  supply_has_shared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_o |-> shared_o);
endmodule

// File: rtl/wu_cpu_fsm.sv
module wu_cpu_fsm
  import wu_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6,
  parameter int DW    = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cpu_req_i,
  input  logic                   cpu_we_i,
  input  logic [IDX_W+TAG_W-1:0] cpu_addr_i,
  input  logic [DW-1:0]          cpu_wdata_i,
  output logic                   cpu_done_o,
  output logic [DW-1:0]          cpu_rdata_o,
  output logic                   bus_req_o,
  input  logic                   bus_gnt_i,
  output bus_cmd_e               bus_cmd_o,
  output logic [IDX_W+TAG_W-1:0] bus_addr_o,
  output logic [DW-1:0]          bus_wdata_o,
  input  logic [DW-1:0]          bus_rdata_i,
  input  logic                   bus_shared_i,
  input  logic                   stall_i,
  input  line_st_e               ln_st_i,
  input  logic [TAG_W-1:0]       ln_tag_i,
  input  logic [DW-1:0]          ln_data_i,
  output logic                   wr_o,
  output line_st_e               wst_o,
  output logic [TAG_W-1:0]       wtag_o,
  output logic [DW-1:0]          wdata_o
);
  ctl_e ctl_q, ctl_d;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit;
  assign idx = cpu_addr_i[IDX_W-1:0];
  assign tag = cpu_addr_i[IDX_W+TAG_W-1:IDX_W];
  assign hit = (ln_st_i != LN_I) && (ln_tag_i == tag);

  always_comb begin
    ctl_d       = ctl_q;
    cpu_done_o  = 1'b0;
    bus_req_o   = 1'b0;
    bus_cmd_o   = BUS_IDLE;
    bus_addr_o  = cpu_addr_i;
    bus_wdata_o = cpu_wdata_i;
    wr_o        = 1'b0;
    wst_o       = ln_st_i;
    wtag_o      = ln_tag_i;
    wdata_o     = ln_data_i;
    unique case (ctl_q)
      CTL_IDLE: if (cpu_req_i && !stall_i) begin
        if (hit) begin
          if (!cpu_we_i) cpu_done_o = 1'b1;
          else if (ln_st_i == LN_SC || ln_st_i == LN_SD) ctl_d = CTL_UPD;
          else begin
            cpu_done_o = 1'b1;
            wr_o       = 1'b1;
            wst_o      = LN_ED;
            wdata_o    = cpu_wdata_i;
          end
        end else ctl_d = st_dirty(ln_st_i) ? CTL_WB : CTL_FILL;
      end
      CTL_UPD: begin
        bus_req_o = 1'b1;
        bus_cmd_o = BUS_UPD;
        if (bus_gnt_i) begin
          cpu_done_o = 1'b1;
          wr_o       = 1'b1;
          wst_o      = bus_shared_i ? LN_SD : LN_ED;
          wdata_o    = cpu_wdata_i;
          ctl_d      = CTL_IDLE;
        end
      end
      CTL_WB: begin
        bus_req_o   = 1'b1;
        bus_cmd_o   = BUS_WB;
        bus_addr_o  = {ln_tag_i, idx};
        bus_wdata_o = ln_data_i;
        if (bus_gnt_i) ctl_d = CTL_FILL;
      end
      CTL_FILL: begin
        bus_req_o = 1'b1;
        bus_cmd_o = BUS_RD;
        if (bus_gnt_i) begin
          wr_o    = 1'b1;
          wst_o   = bus_shared_i ? LN_SC : LN_VE;
          wtag_o  = tag;
          wdata_o = bus_rdata_i;
          ctl_d   = CTL_IDLE;
        end
      end
      default: ctl_d = CTL_IDLE;
    endcase
  end

  assign cpu_rdata_o = ln_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_IDLE;
    else         ctl_q <= ctl_d;
  end

  // R4
  upd_done_at_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o == BUS_UPD) |-> cpu_done_o);

  // R10
  stall_blocks_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !cpu_done_o);
endmodule

// File: rtl/wu_snoop_ctrl.sv
module wu_snoop_ctrl
  import wu_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6,
  parameter int DW    = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cpu_req_i,
  input  logic                   cpu_we_i,
  input  logic [IDX_W+TAG_W-1:0] cpu_addr_i,
  input  logic [DW-1:0]          cpu_wdata_i,
  output logic                   cpu_done_o,
  output logic [DW-1:0]          cpu_rdata_o,
  output logic                   bus_req_o,
  input  logic                   bus_gnt_i,
  output logic [1:0]             bus_cmd_o,
  output logic [IDX_W+TAG_W-1:0] bus_addr_o,
  output logic [DW-1:0]          bus_wdata_o,
  input  logic [DW-1:0]          bus_rdata_i,
  input  logic                   bus_shared_i,
  input  logic                   snp_valid_i,
  input  logic [1:0]             snp_cmd_i,
  input  logic [IDX_W+TAG_W-1:0] snp_addr_i,
  input  logic [DW-1:0]          snp_data_i,
  output logic                   snp_shared_o,
  output logic                   snp_supply_o,
  output logic [DW-1:0]          snp_data_o
);
  localparam int AW = IDX_W + TAG_W;

  line_st_e         a_st, b_st, c_wst, s_wst, w_st;
  logic [TAG_W-1:0] a_tag, b_tag, c_wtag, w_tag;
  logic [DW-1:0]    a_data, b_data, c_wdata, s_wdata, w_data;
  logic             c_wr, s_wr, w_en;
  logic [IDX_W-1:0] w_idx;
  bus_cmd_e         cmd_w;

  // peer snoops only while another master owns the bus
  logic snp_live;
  assign snp_live = snp_valid_i && !bus_gnt_i;

  wu_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (w_en),
    .widx_i   (w_idx),
    .wst_i    (w_st),
    .wtag_i   (w_tag),
    .wdata_i  (w_data),
    .a_idx_i  (cpu_addr_i[IDX_W-1:0]),
    .a_st_o   (a_st),
    .a_tag_o  (a_tag),
    .a_data_o (a_data),
    .b_idx_i  (snp_addr_i[IDX_W-1:0]),
    .b_st_o   (b_st),
    .b_tag_o  (b_tag),
    .b_data_o (b_data)
  );

  wu_snoop_resp #(.TAG_W(TAG_W), .DW(DW)) u_snoop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (snp_live),
    .cmd_i     (bus_cmd_e'(snp_cmd_i)),
    .tag_i     (snp_addr_i[AW-1:IDX_W]),
    .data_i    (snp_data_i),
    .ln_st_i   (b_st),
    .ln_tag_i  (b_tag),
    .ln_data_i (b_data),
    .shared_o  (snp_shared_o),
    .supply_o  (snp_supply_o),
    .data_o    (snp_data_o),
    .wr_o      (s_wr),
    .wst_o     (s_wst),
    .wdata_o   (s_wdata)
  );

  wu_cpu_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_req_i    (cpu_req_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_done_o   (cpu_done_o),
    .cpu_rdata_o  (cpu_rdata_o),
    .bus_req_o    (bus_req_o),
    .bus_gnt_i    (bus_gnt_i),
    .bus_cmd_o    (cmd_w),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_rdata_i  (bus_rdata_i),
    .bus_shared_i (bus_shared_i),
    .stall_i      (s_wr),
    .ln_st_i      (a_st),
    .ln_tag_i     (a_tag),
    .ln_data_i    (a_data),
    .wr_o         (c_wr),
    .wst_o        (c_wst),
    .wtag_o       (c_wtag),
    .wdata_o      (c_wdata)
  );

  assign bus_cmd_o = cmd_w;

  // single store write port, snoop side first
  always_comb begin
    w_en   = s_wr || c_wr;
    w_idx  = s_wr ? snp_addr_i[IDX_W-1:0] : cpu_addr_i[IDX_W-1:0];
    w_st   = s_wr ? s_wst   : c_wst;
    w_tag  = s_wr ? b_tag   : c_wtag;
    w_data = s_wr ? s_wdata : c_wdata;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_cmd_o) && $stable(bus_addr_o)));

  // R5
  wb_then_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o == 2'd3) |=> (bus_req_o && bus_cmd_o == 2'd1));
endmodule

// File: tb/sim_wu_snoop_ctrl.sv
module sim_wu_snoop_ctrl;
  localparam int IDX_W = 2;
  localparam int TAG_W = 6;
  localparam int DW    = 16;
  localparam int AW    = IDX_W + TAG_W;
  localparam int NL    = 1 << IDX_W;
  localparam logic [1:0] C_RD = 2'd1, C_UPD = 2'd2, C_WB = 2'd3, C_NONE = 2'd0;
  localparam logic [2:0] S_I = 0, S_VE = 1, S_SC = 2, S_SD = 3, S_ED = 4;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, bus_shared = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, bus_rdata = '0, snp_data = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_done, bus_req, snp_shared, snp_supply;
  logic [DW-1:0] cpu_rdata, bus_wdata, snp_dout;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;

  wu_snoop_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr), .snp_data_i(snp_data),
    .snp_shared_o(snp_shared), .snp_supply_o(snp_supply), .snp_data_o(snp_dout)
  );

  logic [2:0]       m_st  [NL];
  logic [TAG_W-1:0] m_tag [NL];
  logic [DW-1:0]    m_dat [NL];
  logic [DW-1:0]    mem   [1 << AW];
  int n_chk = 0, n_fail = 0, sh_mode = -1;
  bit done_all = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_dirty(input logic [2:0] s);
    return s == S_SD || s == S_ED;
  endfunction

  function automatic bit pick_sh();
    if (sh_mode >= 0) return sh_mode[0];
    return 1'($urandom_range(0, 1));
  endfunction

  // drive held CPU request to completion, checking the bus and the result
  task automatic cpu_run(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [IDX_W-1:0] ix = a[IDX_W-1:0];
    logic [TAG_W-1:0] tg = a[AW-1:IDX_W];
    bit fin = 0;
    for (int g = 0; g < 60 && !fin; g++) begin
      bit hit, sh;
      logic [1:0] ecmd;
      logic [AW-1:0] eaddr;
      logic [DW-1:0] rd;
      if (g > 0) @(negedge clk);
      bus_gnt = 0;
      #1;
      hit = m_st[ix] != S_I && m_tag[ix] == tg;
      if (hit && we && (m_st[ix] == S_SC || m_st[ix] == S_SD)) begin ecmd = C_UPD; eaddr = a; end
      else if (!hit && is_dirty(m_st[ix])) begin ecmd = C_WB; eaddr = {m_tag[ix], ix}; end
      else if (!hit) begin ecmd = C_RD; eaddr = a; end
      else begin ecmd = C_NONE; eaddr = a; end
      if (bus_req) begin
        chk(bus_cmd == ecmd, "R2/R3/R4/R5 bus cmd", 32'(bus_cmd), 32'(ecmd));
        chk(bus_addr == eaddr, "R2/R4/R5 bus addr", 32'(bus_addr), 32'(eaddr));
        if (ecmd == C_UPD) chk(bus_wdata == d, "R4 update word", 32'(bus_wdata), 32'(d));
        if (ecmd == C_WB) chk(bus_wdata == m_dat[ix], "R5 writeback word", 32'(bus_wdata), 32'(m_dat[ix]));
        if ($urandom_range(0, 2) != 0) begin
          sh = pick_sh();
          rd = sh ? DW'($urandom) : mem[a];
          bus_shared = sh; bus_rdata = rd; bus_gnt = 1;
          #1;
          if (ecmd == C_UPD) begin
            chk(cpu_done == 1'b1, "R4 done at grant", 32'(cpu_done), 1);
            m_dat[ix] = d; m_st[ix] = sh ? S_SD : S_ED; fin = 1;
          end else if (ecmd == C_WB) begin
            mem[eaddr] = m_dat[ix]; m_st[ix] = S_I;
          end else if (ecmd == C_RD) begin
            m_tag[ix] = tg; m_dat[ix] = rd; m_st[ix] = sh ? S_SC : S_VE;
          end
        end
      end else if (cpu_done) begin
        chk(ecmd == C_NONE, "R3 local completion expected", 32'(ecmd), 0);
        if (!we) chk(cpu_rdata == m_dat[ix], "R2 read word", 32'(cpu_rdata), 32'(m_dat[ix]));
        else begin m_dat[ix] = d; m_st[ix] = S_ED; end
        fin = 1;
      end
    end
    chk(fin, "R9 cpu access completes", 32'(fin), 1);
    @(negedge clk);
    cpu_req = 0; bus_gnt = 0; bus_shared = 0;
  endtask

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cpu_run(we, a, d);
  endtask

  // apply snoop in current cycle (caller at negedge), check, update model
  task automatic snoop_now(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [IDX_W-1:0] ix = a[IDX_W-1:0];
    bit hit, sup;
    snp_valid = 1; snp_cmd = c; snp_addr = a; snp_data = d;
    #1;
    hit = (c == C_RD || c == C_UPD) && m_st[ix] != S_I && m_tag[ix] == a[AW-1:IDX_W];
    sup = hit && c == C_RD && is_dirty(m_st[ix]);
    chk(snp_shared == hit, "R6/R7/R8 snoop shared", 32'(snp_shared), 32'(hit));
    chk(snp_supply == sup, "R6/R8 snoop supply", 32'(snp_supply), 32'(sup));
    if (sup) chk(snp_dout == m_dat[ix], "R6 supplied word", 32'(snp_dout), 32'(m_dat[ix]));
    if (hit && c == C_RD) m_st[ix] = is_dirty(m_st[ix]) ? S_SD : S_SC;
    if (hit && c == C_UPD) begin m_st[ix] = S_SC; m_dat[ix] = d; end
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    snoop_now(c, a, d);
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NL; i++) begin m_st[i] = S_I; m_tag[i] = '0; m_dat[i] = '0; end
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(bus_req == 0, "R1 no request after reset", 32'(bus_req), 0);
    chk(cpu_done == 0, "R1 no done after reset", 32'(cpu_done), 0);
    snoop(C_RD, 8'h05, '0);
    snoop(C_RD, 8'h02, '0);
    cpu_op(0, 8'h05, '0);                       // R1/R2 miss read
    // R2 clean exclusive fill, R3 silent write
    sh_mode = 0;
    cpu_op(0, 8'h06, '0);
    cpu_op(1, 8'h06, 16'hBEEF);
    cpu_op(0, 8'h06, '0);
    // R5 dirty eviction then shared fill
    sh_mode = 1;
    cpu_op(0, 8'h0A, '0);
    // R4 write to shared clean, stays shared -> SD
    cpu_op(1, 8'h0A, 16'h1234);
    // R6 snoop read on shared dirty supplies
    snoop(C_RD, 8'h0A, '0);
    // R7 snoop update overwrites
    snoop(C_UPD, 8'h0A, 16'h7777);
    cpu_op(0, 8'h0A, '0);
    // R8 writeback snoop and tag miss ignored
    snoop(C_WB, 8'h0A, 16'h1111);
    snoop(C_UPD, 8'h0E, 16'h2222);
    cpu_op(0, 8'h0A, '0);
    // R4 write to shared line with nobody sharing -> ED, R5 evict
    sh_mode = 0;
    cpu_op(1, 8'h0A, 16'h4444);
    cpu_op(1, 8'h0A, 16'h4545);
    cpu_op(0, 8'h12, '0);
    // R10 snoop read and cpu write same cycle on VE line
    cpu_op(0, 8'h03, '0);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h03; cpu_wdata = 16'hA5A5;
    snoop_now(C_RD, 8'h03, '0);
    chk(cpu_done == 0, "R10 cpu stalled by snoop", 32'(cpu_done), 0);
    @(negedge clk);
    snp_valid = 0;
    cpu_run(1, 8'h03, 16'hA5A5);
    // R10 on exclusive dirty line: supply old word, then update
    cpu_op(1, 8'h12, 16'h5A5A);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h12; cpu_wdata = 16'h6B6B;
    snoop_now(C_RD, 8'h12, '0);
    chk(cpu_done == 0, "R10 cpu stalled on dirty line", 32'(cpu_done), 0);
    @(negedge clk);
    snp_valid = 0;
    cpu_run(1, 8'h12, 16'h6B6B);
    cpu_op(0, 8'h12, '0);
    // random mix
    sh_mode = -1;
    for (int n = 0; n < 500; n++) begin
      logic [AW-1:0] a = {6'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      logic [DW-1:0] d = DW'($urandom);
      int k = $urandom_range(0, 3);
      if (k == 0) cpu_op(0, a, d);
      else if (k == 1) cpu_op(1, a, d);
      else if (k == 2) snoop(C_RD, a, d);
      else if (m_st[a[1:0]] == S_VE || m_st[a[1:0]] == S_ED) snoop(C_RD, a, d);
      else snoop(C_UPD, a, d);
    end
    done_all = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule